// File: doc/BRIEF.md
# Passive-Matrix Colour Panel Line and Frame Timing Generator

This block produces the timing for a small passive-matrix (STN) colour panel. It runs in the pixel clock domain and advances only on cycles where a video clock enable input is high. It counts video clock ticks within a line and lines within a frame. From those counts it drives four outputs: a shift-clock enable, a line pulse, a frame pulse, and a pixel-valid strobe. It also gives the current horizontal and vertical position to an upstream pixel source.

The default panel is 320 by 240. The panel takes one video clock per pixel. Each line also carries four regions of two extra overhead clocks each, so a line is 328 ticks long. A video clock of about 5.8 MHz (about 172 ns per tick) gives a refresh rate near 73 Hz.

The timing windows are whole tick counts:
- The line pulse is high for at least 50 ns.
- At least 70 ns pass between the line pulse and the next shift clock.
- The frame pulse has about 100 ns of setup before the line pulse and 30 ns of hold after it.

At 172 ns per tick, every one of these rounds up to a single tick. The line pulse of a line latches that line's row. The frame pulse marks the pulse that ends line 0.

Top module: `stn_timing_gen`

## Requirements
- R1: A synchronous active-high reset sets the tick and line counters to zero. The cycle after a reset edge, every output is 0: `sclk_en`, `pix_valid`, `line_pulse`, `frame_pulse`, `pix_x` and `pix_y`. The first enabled tick after reset reports position (0,0).
- R2: All outputs change only in the cycle after a clock edge at which `vid_ce` was high. Otherwise they hold their values.
- R3: A line lasts ACT_W + REGIONS*REGION_OVH enabled ticks (328 by default). `pix_x` reports the tick within the line, from 0 to 327. Consecutive line pulse rising edges are exactly 328 ticks apart.
- R4: `pix_valid` and `sclk_en` are equal. They are high for ticks 0 to ACT_W-1 (0 to 319) of every line and low for the overhead ticks. One frame holds 76800 high ticks.
- R5: `line_pulse` is high for HS_HIGH ticks (default 1), starting at tick ACT_W+HS_FRONT (322) of every line. One frame holds 240 pulses.
- R6: After `line_pulse` falls, at least HS_BACK enabled ticks (default 1) pass with `sclk_en` low before `sclk_en` rises again.
- R7: `frame_pulse` is high only on line 0. It rises VS_SETUP ticks before `line_pulse` rises and stays high VS_HOLD ticks after `line_pulse` falls. By default this is ticks 321 to 323 of line 0, so 3 ticks per frame.
- R8: `pix_y` reports the line from 0 to ACT_H-1 (0 to 239). It steps when tick 327 ends and wraps from 239 to 0.
- R9: Every pulse-width parameter is at least 1, and the sync windows fit inside the overhead part of a line; elaboration stops otherwise. Neither `line_pulse` nor `frame_pulse` is ever high together with `pix_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel domain clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_ce | input | 1 | Video clock enable; one tick per high cycle |
| sclk_en | output | 1 | Shift-clock enable to the panel |
| line_pulse | output | 1 | Line latch pulse (HSYNC) |
| frame_pulse | output | 1 | First-line marker (VSYNC) |
| pix_valid | output | 1 | Pixel request strobe to the pixel source |
| pix_x | output | 9 | Tick position within the line |
| pix_y | output | 8 | Line position within the frame |

## Verification
The assertions check the local rules on every cycle:
- outputs hold while the enable is low;
- `sclk_en` always equals `pix_valid`;
- each pulse appears only at the position where it belongs;
- no sync pulse overlaps a valid pixel;
- the gap between the line pulse and the next shift clock holds.

Only the bench scenarios can show the global properties:
- the 328-tick line period;
- the count of valid ticks, line pulses and frame-pulse ticks over one whole frame;
- the wrap of `pix_y` from 239 to 0;
- restart at position (0,0) after a reset taken mid-line.

// File: rtl/stn_timing_pkg.sv
package stn_timing_pkg;

  typedef struct packed {
    logic active;   // shift clock and pixel request
    logic line_p;   // line latch pulse
    logic frame_p;  // first-line marker
  } stn_flags_t;

endpackage

// File: rtl/stn_wrap_counter.sv
module stn_wrap_counter #(
  parameter int unsigned LIMIT = 328,
  parameter int unsigned W     = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         at_last
);

  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign at_last = (count == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (step) begin
      count <= at_last ? '0 : count + 1'b1;
    end
  end

endmodule

// File: rtl/stn_sync_decode.sv
module stn_sync_decode
  import stn_timing_pkg::*;
#(
  parameter int unsigned ACT_W    = 320,
  parameter int unsigned HS_AT    = 322,
  parameter int unsigned HS_HIGH  = 1,
  parameter int unsigned VS_SETUP = 1,
  parameter int unsigned VS_HOLD  = 1,
  parameter int unsigned XW       = 9,
  parameter int unsigned YW       = 8
) (
  input  logic [XW-1:0] hpos,
  input  logic [YW-1:0] vpos,
  output stn_flags_t    flags
);

  localparam logic [XW-1:0] ACT_END = XW'(ACT_W);
  localparam logic [XW-1:0] HS_BEG  = XW'(HS_AT);
  localparam logic [XW-1:0] HS_END  = XW'(HS_AT + HS_HIGH);
  localparam logic [XW-1:0] VS_BEG  = XW'(HS_AT - VS_SETUP);
  localparam logic [XW-1:0] VS_END  = XW'(HS_AT + HS_HIGH + VS_HOLD);

  logic first_line;
  assign first_line = (vpos == '0);

  always_comb begin
    flags         = '0;
    flags.active  = (hpos < ACT_END);
    flags.line_p  = (hpos >= HS_BEG) && (hpos < HS_END);
    flags.frame_p = first_line && (hpos >= VS_BEG) && (hpos < VS_END);
  end

endmodule

// File: rtl/stn_timing_gen.sv
module stn_timing_gen
  import stn_timing_pkg::*;
#(
  parameter int unsigned ACT_W      = 320,
  parameter int unsigned ACT_H      = 240,
  parameter int unsigned REGIONS    = 4,
  parameter int unsigned REGION_OVH = 2,
  parameter int unsigned HS_FRONT   = 2,
  parameter int unsigned HS_HIGH    = 1,
  parameter int unsigned HS_BACK    = 1,
  parameter int unsigned VS_SETUP   = 1,
  parameter int unsigned VS_HOLD    = 1,
  parameter int unsigned XW         = $clog2(ACT_W + REGIONS * REGION_OVH),
  parameter int unsigned YW         = $clog2(ACT_H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vid_ce,
  output logic          sclk_en,
  output logic          line_pulse,
  output logic          frame_pulse,
  output logic          pix_valid,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y
);

  localparam int unsigned H_TOTAL = ACT_W + REGIONS * REGION_OVH;
  localparam int unsigned HS_AT   = ACT_W + HS_FRONT;

  // Layout legality: every window at least one tick, all sync inside overhead
  if (HS_HIGH < 1 || HS_BACK < 1 || VS_SETUP < 1 || VS_HOLD < 1 ||
      VS_SETUP > HS_FRONT ||
      HS_AT + HS_HIGH + VS_HOLD > H_TOTAL ||
      H_TOTAL - HS_AT - HS_HIGH < HS_BACK) begin : g_bad_layout
    $error("stn_timing_gen: sync windows do not fit the line overhead");
  end

  logic [XW-1:0] hcnt;
  logic [YW-1:0] vcnt;
  logic          h_last;
  logic          v_last;
  stn_flags_t    flags;

  stn_wrap_counter #(.LIMIT(H_TOTAL), .W(XW)) u_hcnt (
    .clk     (clk),
    .rst     (rst),
    .step    (vid_ce),
    .count   (hcnt),
    .at_last (h_last)
  );

  stn_wrap_counter #(.LIMIT(ACT_H), .W(YW)) u_vcnt (
    .clk     (clk),
    .rst     (rst),
    .step    (vid_ce && h_last),
    .count   (vcnt),
    .at_last (v_last)
  );

  stn_sync_decode #(
    .ACT_W    (ACT_W),
    .HS_AT    (HS_AT),
    .HS_HIGH  (HS_HIGH),
    .VS_SETUP (VS_SETUP),
    .VS_HOLD  (VS_HOLD),
    .XW       (XW),
    .YW       (YW)
  ) u_dec (
    .hpos  (hcnt),
    .vpos  (vcnt),
    .flags (flags)
  );

  // Registered outputs: each enabled tick publishes the position it covers
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_en     <= 1'b0;
      pix_valid   <= 1'b0;
      line_pulse  <= 1'b0;
      frame_pulse <= 1'b0;
      pix_x       <= '0;
      pix_y       <= '0;
    end else if (vid_ce) begin
      sclk_en     <= flags.active;
      pix_valid   <= flags.active;
      line_pulse  <= flags.line_p;
      frame_pulse <= flags.frame_p;
      pix_x       <= hcnt;
      pix_y       <= vcnt;
    end
  end

  logic unused_vlast;
  assign unused_vlast = v_last;

endmodule

// File: rtl/stn_timing_chk.sv
module stn_timing_chk #(
  parameter int unsigned ACT_W    = 320,
  parameter int unsigned ACT_H    = 240,
  parameter int unsigned H_TOTAL  = 328,
  parameter int unsigned HS_AT    = 322,
  parameter int unsigned HS_HIGH  = 1,
  parameter int unsigned HS_BACK  = 1,
  parameter int unsigned VS_SETUP = 1,
  parameter int unsigned VS_HOLD  = 1,
  parameter int unsigned XW       = 9,
  parameter int unsigned YW       = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          vid_ce,
  input logic          sclk_en,
  input logic          line_pulse,
  input logic          frame_pulse,
  input logic          pix_valid,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] pix_y
);

  localparam int unsigned GW = XW + 1;
  localparam logic [GW-1:0] GAP_SAT = GW'(H_TOTAL);

  logic          ce_d;
  logic [GW-1:0] gap;

  // Counts published ticks since the line pulse was last high
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_d <= 1'b0;
      gap  <= GAP_SAT;
    end else begin
      ce_d <= vid_ce;
      if (ce_d) begin
        if (line_pulse) gap <= '0;
        else if (gap < GAP_SAT) gap <= gap + 1'b1;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!sclk_en && !pix_valid && !line_pulse && !frame_pulse &&
             pix_x == '0 && pix_y == '0));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !vid_ce |=> $stable({sclk_en, pix_valid, line_pulse, frame_pulse, pix_x, pix_y}));

  // R4
  valid_matches_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid == sclk_en) && (!pix_valid || pix_x < XW'(ACT_W)));

  // R5
  line_pulse_place_chk: assert property (@(posedge clk) disable iff (rst)
    line_pulse |-> (pix_x >= XW'(HS_AT) && pix_x < XW'(HS_AT + HS_HIGH)));

  // R6
  back_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_d && $rose(sclk_en)) |-> (gap >= GW'(HS_BACK)));

  // R7
  frame_pulse_place_chk: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> (pix_y == '0 && pix_x >= XW'(HS_AT - VS_SETUP) &&
                     pix_x < XW'(HS_AT + HS_HIGH + VS_HOLD)));

  // R3 R8
  coord_range_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_x < XW'(H_TOTAL)) && (pix_y < YW'(ACT_H)));

  // R9
  sync_outside_active_chk: assert property (@(posedge clk) disable iff (rst)
    (line_pulse || frame_pulse) |-> !pix_valid);

endmodule

bind stn_timing_gen stn_timing_chk #(
  .ACT_W    (ACT_W),
  .ACT_H    (ACT_H),
  .H_TOTAL  (ACT_W + REGIONS * REGION_OVH),
  .HS_AT    (ACT_W + HS_FRONT),
  .HS_HIGH  (HS_HIGH),
  .HS_BACK  (HS_BACK),
  .VS_SETUP (VS_SETUP),
  .VS_HOLD  (VS_HOLD),
  .XW       (XW),
  .YW       (YW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .vid_ce      (vid_ce),
  .sclk_en     (sclk_en),
  .line_pulse  (line_pulse),
  .frame_pulse (frame_pulse),
  .pix_valid   (pix_valid),
  .pix_x       (pix_x),
  .pix_y       (pix_y)
);

// File: tb/tb_stn_timing_gen.sv
module tb_stn_timing_gen;

  localparam int ACT_W   = 320;
  localparam int ACT_H   = 240;
  localparam int H_TOTAL = 328;
  localparam int HS_AT   = 322;
  localparam int VS_BEG  = 321;
  localparam int VS_END  = 324;
  localparam int FRAME_TICKS = H_TOTAL * ACT_H;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vid_ce = 1'b0;
  logic       sclk_en, line_pulse, frame_pulse, pix_valid;
  logic [8:0] pix_x;
  logic [7:0] pix_y;

  always #5 clk = ~clk;

  stn_timing_gen dut (
    .clk(clk), .rst(rst), .vid_ce(vid_ce),
    .sclk_en(sclk_en), .line_pulse(line_pulse), .frame_pulse(frame_pulse),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y)
  );

  typedef struct {
    bit v; bit h; bit f; int x; int y;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   mx, my;
  int   total = 0, bad = 0;
  bit   finished = 0;

  // observation statistics
  int   n_pop = 0, cnt_valid = 0, cnt_hs = 0, cnt_vs = 0;
  int   gap = 1000, min_gap = 1000, last_hs_idx = -1;
  bit   prev_valid = 0, prev_hs = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input int x, input int y);
    exp_t e;
    e.v = (x < ACT_W);
    e.h = (x >= HS_AT) && (x < HS_AT + 1);
    e.f = (y == 0) && (x >= VS_BEG) && (x < VS_END);
    e.x = x;
    e.y = y;
    return e;
  endfunction

  function automatic exp_t zero_item();
    exp_t e;
    e.v = 0; e.h = 0; e.f = 0; e.x = 0; e.y = 0;
    return e;
  endfunction

  // driver: one cycle, optionally an enabled tick with its expected item
  task automatic tick(input bit ce);
    @(negedge clk);
    vid_ce = ce;
    if (ce) begin
      q.push_back(model(mx, my));
      mx++;
      if (mx == H_TOTAL) begin
        mx = 0;
        my = (my + 1) % ACT_H;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    vid_ce = 0;
    @(negedge clk);
    rst = 1;
    q.delete();
    last = zero_item();
    mx = 0; my = 0;
    gap = 1000; last_hs_idx = -1; prev_valid = 0; prev_hs = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic check_reset_state(input string tag);
    chk(sclk_en == 0 && pix_valid == 0, "R1", {tag, " strobes"}, {sclk_en, pix_valid}, 0);
    chk(line_pulse == 0 && frame_pulse == 0, "R1", {tag, " syncs"}, {line_pulse, frame_pulse}, 0);
    chk(pix_x == 0 && pix_y == 0, "R1", {tag, " coords"}, pix_x + pix_y, 0);
  endtask

  task automatic compare(input exp_t e, input string req_ctx);
    chk(pix_valid == e.v, "R4", {req_ctx, " pix_valid"}, pix_valid, e.v);
    chk(sclk_en == e.v, "R4", {req_ctx, " sclk_en"}, sclk_en, e.v);
    chk(line_pulse == e.h, "R5", {req_ctx, " line_pulse"}, line_pulse, e.h);
    chk(frame_pulse == e.f, "R7", {req_ctx, " frame_pulse"}, frame_pulse, e.f);
    chk(int'(pix_x) == e.x, "R3", {req_ctx, " pix_x"}, pix_x, e.x);
    chk(int'(pix_y) == e.y, "R8", {req_ctx, " pix_y"}, pix_y, e.y);
  endtask

  // monitor: pops one expected item per enabled tick, else checks hold
  initial begin
    last = zero_item();
    forever begin
      @(posedge clk);
      if (!rst && vid_ce) begin
        @(negedge clk);
        if (q.size() == 0) begin
          chk(0, "R2", "unexpected tick, empty queue", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          compare(e, "tick");
          last = e;
          n_pop++;
          if (n_pop <= FRAME_TICKS) begin
            cnt_valid += pix_valid;
            cnt_hs    += (line_pulse && !prev_hs);
            cnt_vs    += frame_pulse;
          end
          if ((line_pulse || frame_pulse) && pix_valid)
            chk(0, "R9", "sync overlaps valid", 1, 0);
          if (pix_valid && !prev_valid && gap < min_gap) min_gap = gap;
          if (line_pulse && !prev_hs) begin
            if (last_hs_idx >= 0)
              chk(n_pop - last_hs_idx == H_TOTAL, "R3", "line period", n_pop - last_hs_idx, H_TOTAL);
            last_hs_idx = n_pop;
          end
          if (line_pulse) gap = 0; else if (gap < 1000) gap++;
          prev_valid = pix_valid;
          prev_hs = line_pulse;
        end
      end else if (!rst) begin
        @(negedge clk);
        if (!rst) compare(last, "R2 hold");
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    mx = 0; my = 0;
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_reset_state("R1 after power-on reset");
    repeat (5) tick(0);                       // R2: idle keeps zeros
    // first lines with gaps in the enable, then one full frame and more
    for (int i = 0; i < 3000; i++) tick((i % 7) != 3);
    while (n_pop + q.size() < FRAME_TICKS + 700) tick(1);
    repeat (3) tick(0);
    chk(cnt_valid == ACT_W * ACT_H, "R4", "valid ticks per frame", cnt_valid, ACT_W * ACT_H);
    chk(cnt_hs == ACT_H, "R5", "line pulses per frame", cnt_hs, ACT_H);
    chk(cnt_vs == 3, "R7", "frame pulse ticks per frame", cnt_vs, 3);
    chk(min_gap >= 1, "R6", "ticks from line pulse to shift clock", min_gap, 1);
    chk(n_pop > FRAME_TICKS, "R8", "frame wrap reached", n_pop, FRAME_TICKS + 1);
    // reset taken mid-line, then restart from (0,0) and cross line 0 pulse
    for (int i = 0; i < 150; i++) tick(1);
    do_reset();
    @(negedge clk);
    check_reset_state("R1 after mid-line reset");
    for (int i = 0; i < 700; i++) tick((i % 5) != 0);
    repeat (3) tick(0);
    chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    chk(bad == 0, "R9", "no sync/valid overlap seen", bad, 0);
    finish_run();
  end

endmodule